// File: doc/BRIEF.md
# Selectable Burst Address Sequencer

This block produces the low-order offset of a memory address during a burst. An address strobe captures the external address. Either of two strobe inputs can start the cycle. The strobe loads the two low bits as the starting offset of the burst. It also captures the upper bits, which are then held fixed for the rest of the burst. Each cycle with the advance input high moves the offset one beat further. Cycles without advance leave the offset where it is.

Two beat orders are available. The linear order counts up and wraps at four. The interleaved order takes the starting offset XOR the beat number. The mode input chooses between them. Mode is sampled on the strobe edge, so one burst always follows one order from start to finish. A strobe on the same edge as an advance wins: the counter reloads instead of stepping. The outputs are the full registered burst address and, separately, the current offset.

Top module: `sbs_burst_seq`

## Requirements
- R1: While rst_n is low, and after it rises with no strobe seen, addr_out is all zeros and burst_ofs is 0.
- R2: A clock edge with strobe_cpu or strobe_ctl high, or both, sets burst_ofs to addr_in[1:0] and addr_out to addr_in. The new values are visible after that edge.
- R3: When interleave was 0 at the last strobe, each edge with adv high and no strobe raises burst_ofs by one modulo 4 (start 1 gives 1, 2, 3, 0).
- R4: When interleave was 1 at the last strobe, the offset at beat n equals the start offset XOR n (start 1 gives 1, 0, 3, 2).
- R5: An edge with no strobe and adv low leaves addr_out and burst_ofs unchanged.
- R6: A strobe on the same edge as adv reloads from addr_in and does not step the offset.
- R7: After four advances the offset returns to the start offset. Without a strobe, addr_out[16:2] keeps the captured upper bits, whatever addr_in does.
- R8: The order is fixed by interleave as sampled on the strobe edge. Changing interleave in the middle of a burst has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_cpu | input | 1 | Processor-side address strobe, starts a burst |
| strobe_ctl | input | 1 | Controller-side address strobe, starts a burst |
| adv | input | 1 | Advance the burst by one beat |
| interleave | input | 1 | 1 selects the XOR order, 0 the linear order; sampled on a strobe |
| addr_in | input | 17 | External address |
| addr_out | output | 17 | Captured upper bits joined with the current offset |
| burst_ofs | output | 2 | Current burst offset |

## Verification
The hardest case to produce from the ports is a change of interleave partway through a burst that has already wrapped. The captured mode is visible only through the order of the offsets that follow. The stimulus therefore starts an interleaved burst and walks it through all four beats. It flips interleave to 0 before the wrap and advances once more, so a design that reads the live pin gives a linear offset at that point instead of the XOR offset. Strobe-with-advance collisions and changes on addr_in without a strobe are placed right after full bursts, where a wrong step or a leak into the upper bits shows up at once.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int OFS_W = 2;

    typedef struct packed {
        logic [OFS_W-1:0] start;
        logic [OFS_W-1:0] beat;
        logic             xor_mode;
    } beat_state_t;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;
endpackage

// File: rtl/sbs_beat_ctr.sv
module sbs_beat_ctr
    import sbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic [OFS_W-1:0] start_in,
    input  logic             mode_in,
    output logic [OFS_W-1:0] start_q,
    output logic [OFS_W-1:0] beat_q,
    output logic             mode_q
);
    beat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.start    = start_in;
            st_d.beat     = '0;
            st_d.xor_mode = mode_in;
        end else if (adv) begin
            st_d.beat = st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_q = st_q.start;
    assign beat_q  = st_q.beat;
    assign mode_q  = st_q.xor_mode;

    // R6: a load restarts the beat count even when adv is high
    assert_load_clears_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat_q == '0));

    // R8: the captured mode stays put between loads
    assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mode_q));
endmodule

// File: rtl/sbs_ofs_map.sv
module sbs_ofs_map
    import sbs_pkg::*;
(
    input  logic [OFS_W-1:0] start,
    input  logic [OFS_W-1:0] beat,
    input  logic             mode,
    output logic [OFS_W-1:0] ofs
);
    logic [OFS_W-1:0] lin_ofs;
    logic [OFS_W-1:0] xor_ofs;

    assign lin_ofs = start + beat;

    for (genvar b = 0; b < OFS_W; b++) begin : g_xor_bit
        assign xor_ofs[b] = start[b] ^ beat[b];
    end

    always_comb begin
        unique case (order_e'(mode))
            ORDER_XOR:    ofs = xor_ofs;
            default:      ofs = lin_ofs;
        endcase
    end

    // R4: at beat zero both orders agree on the start offset
    always_comb begin
        if (beat == '0) assert_beat0_start_R4: assert (ofs == start);
    end
endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              adv,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [OFS_W-1:0]  burst_ofs
);
    localparam int UP_W = ADDR_W - OFS_W;

    logic             load;
    logic [OFS_W-1:0] start_q, beat_q;
    logic             mode_q;
    logic [UP_W-1:0]  upper_d, upper_q;

    assign load = strobe_cpu | strobe_ctl;

    sbs_beat_ctr u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .adv     (adv),
        .start_in(addr_in[OFS_W-1:0]),
        .mode_in (interleave),
        .start_q (start_q),
        .beat_q  (beat_q),
        .mode_q  (mode_q)
    );

    sbs_ofs_map u_map (
        .start(start_q),
        .beat (beat_q),
        .mode (mode_q),
        .ofs  (burst_ofs)
    );

    always_comb begin
        upper_d = upper_q;
        if (load) upper_d = addr_in[ADDR_W-1:OFS_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) upper_q <= '0;
        else        upper_q <= upper_d;
    end

    assign addr_out = {upper_q, burst_ofs};

    // R2: either strobe captures the whole external address
    assert_strobe_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr_out == $past(addr_in)));

    // R5: no strobe and no advance keeps the address still
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(addr_out));

    // R7: upper bits only move on a strobe
    assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_out[ADDR_W-1:OFS_W]));

    // R3: linear order steps by one
    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv && !mode_q) |=> (burst_ofs == OFS_W'($past(burst_ofs) + 1'b1)));

    // R4: XOR order always moves to a different offset on advance
    assert_xor_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv && mode_q) |=> (burst_ofs != $past(burst_ofs)));
endmodule

// File: tb/sbs_burst_seq_test.sv
module sbs_burst_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;
    localparam int NVEC = 15;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          strobe_cpu = 0, strobe_ctl = 0, adv = 0, interleave = 0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic [1:0]    burst_ofs;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbs_burst_seq uut (
        .clk(clk), .rst_n(rst_n), .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
        .adv(adv), .interleave(interleave), .addr_in(addr_in),
        .addr_out(addr_out), .burst_ofs(burst_ofs)
    );

    // {cpu, ctl, adv, mode, addr_in[16:0], expected addr_out[16:0]}
    localparam logic [37:0] VEC [NVEC] = '{
        {4'b1000, 17'h0ABC5, 17'h0ABC5}, // R2 cpu strobe, linear, start 1
        {4'b0010, 17'h00000, 17'h0ABC6}, // R3
        {4'b0010, 17'h00000, 17'h0ABC7}, // R3
        {4'b0010, 17'h00000, 17'h0ABC4}, // R3 wrap 3->0
        {4'b0010, 17'h00000, 17'h0ABC5}, // R7 back to start
        {4'b0000, 17'h1FFFF, 17'h0ABC5}, // R5 idle hold
        {4'b0101, 17'h12345, 17'h12345}, // R2 ctl strobe, xor, start 1
        {4'b0011, 17'h00000, 17'h12344}, // R4 1^1
        {4'b0011, 17'h00000, 17'h12347}, // R4 1^2
        {4'b0011, 17'h00000, 17'h12346}, // R4 1^3
        {4'b0010, 17'h00000, 17'h12345}, // R8 mode pin now 0, still xor, wrap
        {4'b0010, 17'h00000, 17'h12344}, // R8 xor beat 1 (linear would give 2)
        {4'b1011, 17'h1FFFE, 17'h1FFFE}, // R6 strobe beats adv
        {4'b0011, 17'h00000, 17'h1FFFF}, // R4 2^1
        {4'b0011, 17'h00000, 17'h1FFFC}  // R7 upper held, 2^2
    };

    task automatic check(string req, logic [AW-1:0] exp_a);
        n_run++;
        if (addr_out !== exp_a || burst_ofs !== exp_a[1:0]) begin
            n_fail++;
            $display("FAIL %s: addr_out=%h ofs=%0d expected addr_out=%h ofs=%0d",
                     req, addr_out, burst_ofs, exp_a, exp_a[1:0]);
        end
    endtask

    task automatic step(logic c, logic t, logic a, logic m, logic [AW-1:0] ai);
        @(negedge clk);
        strobe_cpu = c; strobe_ctl = t; adv = a; interleave = m; addr_in = ai;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1 in reset", '0);
        @(negedge clk) rst_n = 1;
        @(posedge clk); #1 check("R1 after reset", '0);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][37], VEC[i][36], VEC[i][35], VEC[i][34], VEC[i][33:17]);
            check($sformatf("vector %0d (R2-R8)", i), VEC[i][16:0]);
        end

        // R2 both strobes together, linear from start 3
        step(1, 1, 0, 0, 17'h05553);
        check("R2 both strobes", 17'h05553);
        step(0, 0, 1, 1, 17'h0);
        check("R3 linear 3->0", 17'h05550);
        // R5 idle with addr_in and mode changing
        step(0, 0, 0, 1, 17'h1AAAA);
        check("R5 hold", 17'h05550);
        // R6 ctl strobe plus adv, xor start 0
        step(0, 1, 1, 1, 17'h00008);
        check("R6 reload", 17'h00008);
        step(0, 0, 1, 0, 17'h0);
        check("R4 0^1", 17'h00009);
        // R1 reset mid-burst
        @(negedge clk) rst_n = 0;
        @(posedge clk); #1 check("R1 mid-run reset", '0);
        @(negedge clk) rst_n = 1;

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule